// File: doc/BRIEF.md
# Cell Buffer with Width Conversion

This block sits between a local packet source and a cell-bus transmitter. It buffers one port's cells. The source streams words with a start-of-packet mark, an error flag and an odd parity bit. The buffer checks that every start-of-packet mark falls on a cell boundary. Storage is claimed and given back only in whole cells, so the transmitter never sees part of a cell.

Octets are kept in order inside an octet-addressed ring. The input width and the output width can therefore be chosen separately. Octet zero of a cell always sits in the most significant byte of a word. When the cell length is not a multiple of the input word size, the unused octets are the least significant octets of the first input word, and they are ignored. With 64-bit input and 52-octet cells this means the low 32 bits of the first word are dropped. With 56-octet cells, the header, check octet and three spare octets fill the first 64-bit word.

A cell that has a problem leaves no trace in storage. This covers a cell that overflows, has no start mark, is cut short by a stray start mark, or carries an error or parity fault. The write side returns to the last committed cell boundary. All status outputs are single-cycle pulses. Each appears in the cycle after the input that caused it.

Top module: `cellbuf`

## Requirements
- R1: After reset, `ready_o` is 1, `avail_o` is 0 and every status pulse is 0.
- R2: Up to NCELLS complete cells are held. `ready_o` is 1 exactly while fewer than NCELLS cells are stored. A cell still being read counts as stored until its last word is read.
- R3: A word with `in_sop_i`=1 that is accepted while `ready_o`=0 starts a cell that is dropped whole. `ovf_err_o` pulses once in the next cycle.
- R4: Every accepted word with `in_sop_i`=1 gives one `soc_o` pulse in the next cycle.
- R5: `soc_err_o` pulses in the following two cases, and the affected cell is never stored.
  - The first word of a cell arrives without `in_sop_i`. The whole cell is then discarded.
  - `in_sop_i` arrives partway through a cell. The partial cell is abandoned and a new cell starts with that word.
- R6: Octet order is most significant byte first on both sides. The octets that the cell length leaves over are the least significant octets of the first input word, and they are ignored. The output carries the cell octets in order, OUT_W/8 octets per word.
- R7: While `avail_o`=1, `out_sop_o` marks the first word of a cell and `out_eop_o` marks its last word.
- R8: A read (`rd_en_i`=1) while `avail_o`=0 changes nothing. `udf_err_o` pulses in the next cycle.
- R9: A word whose data bits and `in_par_i` have an even number of ones raises `par_err_o` in the next cycle. A parity fault, or `in_err_i`=1 on any word, discards the whole cell.
- R10: `avail_o` rises only after the last word of a good cell has been accepted. It stays high until the last word of every stored cell has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid |
| in_data_i | input | IN_W | Input word |
| in_sop_i | input | 1 | Start-of-packet mark |
| in_err_i | input | 1 | Source flags this word as bad |
| in_par_i | input | 1 | Odd parity over in_data_i |
| ready_o | output | 1 | Space for one full cell is free |
| rd_en_i | input | 1 | Transmitter takes the current output word |
| avail_o | output | 1 | At least one full cell is stored |
| out_data_o | output | OUT_W | Current output word |
| out_sop_o | output | 1 | Output word is the first word of a cell |
| out_eop_o | output | 1 | Output word is the last word of a cell |
| soc_o | output | 1 | Start-of-cell pulse |
| soc_err_o | output | 1 | Misplaced or missing start mark pulse |
| ovf_err_o | output | 1 | Overflow drop pulse |
| par_err_o | output | 1 | Parity fault pulse |
| udf_err_o | output | 1 | Read while empty pulse |

## Verification
The assertions check cause and effect on every cycle:
- an overflow pulse only follows a start mark seen while `ready_o` was low;
- a start-of-cell pulse only follows a start mark;
- an underflow pulse only follows a read while empty;
- a full buffer always shows data available;
- a cell that is partly read stays available until its end mark.

Some behaviour is visible only in the bench's scenarios. This includes octet placement across the width change, dropping of the padding octets, and the rollback that keeps broken or overflowing cells out of storage. It also includes cells being written and read in the same cycles. The scoreboard compares every output word, with its cell marks, against cells built from the requirements.

// File: rtl/cellbuf_pkg.sv
package cellbuf_pkg;

    typedef struct packed {
        logic soc;
        logic soc_err;
        logic ovf;
        logic par_err;
    } wr_flags_t;

    // Add two offsets in a ring of 'depth' entries; a + b stays below 2*depth.
    function automatic int unsigned ring_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned depth);
        int unsigned s;
        s = a + b;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/cellbuf_store.sv
module cellbuf_store #(
    parameter int DEPTH = 208,
    parameter int AW    = 8,
    parameter int IN_B  = 8,
    parameter int OUT_B = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [IN_B-1:0]            we_i,
    input  logic [IN_B-1:0][AW-1:0]    waddr_i,
    input  logic [IN_B-1:0][7:0]       wdata_i,
    input  logic [OUT_B-1:0][AW-1:0]   raddr_i,
    output logic [OUT_B-1:0][7:0]      rdata_o
);

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int k = 0; k < IN_B; k++) begin
            if (we_i[k]) begin
                mem_d[waddr_i[k]] = wdata_i[k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        for (int j = 0; j < OUT_B; j++) begin
            rdata_o[j] = mem_q[raddr_i[j]];
        end
    end

endmodule

// File: rtl/cellbuf_wr.sv
module cellbuf_wr
    import cellbuf_pkg::*;
#(
    parameter int IN_W     = 64,
    parameter int CELL_OCT = 52,
    parameter int NCELLS   = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          in_valid_i,
    input  logic [IN_W-1:0]               in_data_i,
    input  logic                          in_sop_i,
    input  logic                          in_err_i,
    input  logic                          in_par_i,
    input  logic                          can_take_i,
    output logic [IN_W/8-1:0]             lane_we_o,
    output logic [IN_W/8-1:0][$clog2(NCELLS*CELL_OCT)-1:0] lane_addr_o,
    output logic [IN_W/8-1:0][7:0]        lane_data_o,
    output logic                          commit_o,
    output wr_flags_t                     flags_o
);

    localparam int IN_B     = IN_W / 8;
    localparam int DEPTH    = NCELLS * CELL_OCT;
    localparam int AW       = $clog2(DEPTH);
    localparam int IN_WORDS = (CELL_OCT + IN_B - 1) / IN_B;
    localparam int PAD      = IN_WORDS * IN_B - CELL_OCT;
    localparam int LEAD     = IN_B - PAD;
    localparam int WW       = $clog2(IN_WORDS + 1);
    localparam int OW       = $clog2(CELL_OCT + 1);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [OW-1:0] off;
        logic [WW-1:0] wcnt;
        logic          drop;
        logic          bad;
        wr_flags_t     flags;
    } wr_state_t;

    wr_state_t q, d;

    logic          par_ok, start, drop_now, bad_now, bad_next, last;
    logic [OW-1:0] off_now, nval;
    logic [WW-1:0] widx;

    always_comb begin
        d        = q;
        d.flags  = '0;
        commit_o = 1'b0;
        par_ok   = ^{in_data_i, in_par_i};
        start    = in_sop_i || (q.wcnt == '0);
        drop_now = start ? (!in_sop_i || !can_take_i) : q.drop;
        bad_now  = start ? 1'b0 : q.bad;
        off_now  = start ? '0 : q.off;
        widx     = start ? '0 : q.wcnt;
        nval     = (widx == '0) ? OW'(LEAD) : OW'(IN_B);
        bad_next = bad_now || in_err_i || !par_ok;
        last     = (widx == WW'(IN_WORDS - 1));

        if (in_valid_i) begin
            d.flags.soc     = in_sop_i;
            d.flags.soc_err = in_sop_i ? (q.wcnt != '0) : (q.wcnt == '0);
            d.flags.ovf     = in_sop_i && !can_take_i;
            d.flags.par_err = !par_ok;
            if (last) begin
                d.wcnt = '0;
                d.off  = '0;
                d.drop = 1'b0;
                d.bad  = 1'b0;
                if (!drop_now && !bad_next) begin
                    commit_o = 1'b1;
                    d.base   = AW'(ring_add(int'(q.base), CELL_OCT, DEPTH));
                end
            end else begin
                d.wcnt = widx + WW'(1);
                d.off  = off_now + nval;
                d.drop = drop_now;
                d.bad  = bad_next;
            end
        end

        for (int j = 0; j < IN_B; j++) begin
            lane_data_o[j] = in_data_i[IN_W-1-8*j -: 8];
            lane_we_o[j]   = in_valid_i && !drop_now && (j < int'(nval));
            lane_addr_o[j] = AW'(ring_add(int'(q.base), int'(off_now) + j, DEPTH));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flags_o = q.flags;

endmodule

// File: rtl/cellbuf_rd.sv
module cellbuf_rd
    import cellbuf_pkg::*;
#(
    parameter int OUT_W    = 32,
    parameter int CELL_OCT = 52,
    parameter int NCELLS   = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      rd_en_i,
    input  logic                      have_cell_i,
    output logic [OUT_W/8-1:0][$clog2(NCELLS*CELL_OCT)-1:0] raddr_o,
    output logic                      sop_o,
    output logic                      eop_o,
    output logic                      release_o,
    output logic                      udf_o
);

    localparam int OUT_B     = OUT_W / 8;
    localparam int DEPTH     = NCELLS * CELL_OCT;
    localparam int AW        = $clog2(DEPTH);
    localparam int OUT_WORDS = CELL_OCT / OUT_B;
    localparam int RW        = $clog2(OUT_WORDS + 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [RW-1:0] rword;
        logic          udf;
    } rd_state_t;

    rd_state_t q, d;

    always_comb begin
        d         = q;
        d.udf     = 1'b0;
        release_o = 1'b0;
        if (rd_en_i) begin
            if (have_cell_i) begin
                d.ptr = AW'(ring_add(int'(q.ptr), OUT_B, DEPTH));
                if (q.rword == RW'(OUT_WORDS - 1)) begin
                    d.rword   = '0;
                    release_o = 1'b1;
                end else begin
                    d.rword = q.rword + RW'(1);
                end
            end else begin
                d.udf = 1'b1;
            end
        end
        for (int j = 0; j < OUT_B; j++) begin
            raddr_o[j] = AW'(ring_add(int'(q.ptr), j, DEPTH));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sop_o = (q.rword == '0);
    assign eop_o = (q.rword == RW'(OUT_WORDS - 1));
    assign udf_o = q.udf;

endmodule

// File: rtl/cellbuf.sv
module cellbuf
    import cellbuf_pkg::*;
#(
    parameter int IN_W     = 64,
    parameter int OUT_W    = 32,
    parameter int CELL_OCT = 52,
    parameter int NCELLS   = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_valid_i,
    input  logic [IN_W-1:0]  in_data_i,
    input  logic             in_sop_i,
    input  logic             in_err_i,
    input  logic             in_par_i,
    output logic             ready_o,
    input  logic             rd_en_i,
    output logic             avail_o,
    output logic [OUT_W-1:0] out_data_o,
    output logic             out_sop_o,
    output logic             out_eop_o,
    output logic             soc_o,
    output logic             soc_err_o,
    output logic             ovf_err_o,
    output logic             par_err_o,
    output logic             udf_err_o
);

    localparam int IN_B  = IN_W / 8;
    localparam int OUT_B = OUT_W / 8;
    localparam int DEPTH = NCELLS * CELL_OCT;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(NCELLS + 1);

    typedef struct packed {
        logic [CW-1:0] cells;
    } occ_t;

    occ_t occ_d, occ_q;

    logic [IN_B-1:0]           lane_we;
    logic [IN_B-1:0][AW-1:0]   lane_addr;
    logic [IN_B-1:0][7:0]      lane_data;
    logic [OUT_B-1:0][AW-1:0]  raddr;
    logic [OUT_B-1:0][7:0]     rdata;
    logic                      commit, release_c;
    wr_flags_t                 wflags;

    assign ready_o = (occ_q.cells < CW'(NCELLS));
    assign avail_o = (occ_q.cells != '0);

    cellbuf_wr #(.IN_W(IN_W), .CELL_OCT(CELL_OCT), .NCELLS(NCELLS)) u_wr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_sop_i    (in_sop_i),
        .in_err_i    (in_err_i),
        .in_par_i    (in_par_i),
        .can_take_i  (ready_o),
        .lane_we_o   (lane_we),
        .lane_addr_o (lane_addr),
        .lane_data_o (lane_data),
        .commit_o    (commit),
        .flags_o     (wflags)
    );

    cellbuf_store #(.DEPTH(DEPTH), .AW(AW), .IN_B(IN_B), .OUT_B(OUT_B)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (lane_we),
        .waddr_i (lane_addr),
        .wdata_i (lane_data),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    cellbuf_rd #(.OUT_W(OUT_W), .CELL_OCT(CELL_OCT), .NCELLS(NCELLS)) u_rd (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_en_i     (rd_en_i),
        .have_cell_i (avail_o),
        .raddr_o     (raddr),
        .sop_o       (out_sop_o),
        .eop_o       (out_eop_o),
        .release_o   (release_c),
        .udf_o       (udf_err_o)
    );

    for (genvar j = 0; j < OUT_B; j++) begin : g_out
        assign out_data_o[OUT_W-1-8*j -: 8] = rdata[j];
    end

    always_comb begin
        occ_d       = occ_q;
        occ_d.cells = occ_q.cells + CW'(commit) - CW'(release_c);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign soc_o     = wflags.soc;
    assign soc_err_o = wflags.soc_err;
    assign ovf_err_o = wflags.ovf;
    assign par_err_o = wflags.par_err;

endmodule

// File: rtl/cellbuf_chk.sv
module cellbuf_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic in_valid_i,
    input logic in_sop_i,
    input logic ready_o,
    input logic avail_o,
    input logic rd_en_i,
    input logic out_eop_o,
    input logic soc_o,
    input logic ovf_err_o,
    input logic udf_err_o
);

    p_full_means_avail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> avail_o);

    p_ovf_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_err_o |-> $past(in_valid_i && in_sop_i && !ready_o));

    p_ovf_with_soc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_err_o |-> soc_o);

    p_soc_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soc_o |-> $past(in_valid_i && in_sop_i));

    p_udf_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        udf_err_o |-> $past(rd_en_i && !avail_o));

    p_cell_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (avail_o && rd_en_i && !out_eop_o) |=> avail_o);

endmodule

bind cellbuf cellbuf_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_sop_i   (in_sop_i),
    .ready_o    (ready_o),
    .avail_o    (avail_o),
    .rd_en_i    (rd_en_i),
    .out_eop_o  (out_eop_o),
    .soc_o      (soc_o),
    .ovf_err_o  (ovf_err_o),
    .udf_err_o  (udf_err_o)
);

// File: tb/tb_cellbuf.sv
module tb_cellbuf;

    localparam int IN_W      = 64;
    localparam int OUT_W     = 32;
    localparam int CELL_OCT  = 52;
    localparam int NCELLS    = 4;
    localparam int IN_B      = IN_W / 8;
    localparam int OUT_B     = OUT_W / 8;
    localparam int IN_WORDS  = (CELL_OCT + IN_B - 1) / IN_B;
    localparam int LEAD      = IN_B - (IN_WORDS * IN_B - CELL_OCT);
    localparam int OUT_WORDS = CELL_OCT / OUT_B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_err = 1'b0, in_par = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic rd_en = 1'b0;
    logic ready, avail, out_sop, out_eop, soc, soc_err, ovf_err, par_err, udf_err;
    logic [OUT_W-1:0] out_data;

    int checks = 0, errors = 0;
    int n_soc = 0, n_serr = 0, n_ovf = 0, n_par = 0, n_udf = 0;
    bit drain = 1'b0, poke = 1'b0, done = 1'b0;
    logic [OUT_W+1:0] exp_q[$];

    always #10 clk = ~clk;

    cellbuf #(.IN_W(IN_W), .OUT_W(OUT_W), .CELL_OCT(CELL_OCT), .NCELLS(NCELLS)) dut (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
        .in_sop_i(in_sop), .in_err_i(in_err), .in_par_i(in_par), .ready_o(ready),
        .rd_en_i(rd_en), .avail_o(avail), .out_data_o(out_data), .out_sop_o(out_sop),
        .out_eop_o(out_eop), .soc_o(soc), .soc_err_o(soc_err), .ovf_err_o(ovf_err),
        .par_err_o(par_err), .udf_err_o(udf_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] oct(input int c, input int i);
        return 8'((c * 29 + i * 7 + 3) & 255);
    endfunction

    function automatic logic [IN_W-1:0] in_word(input int c, input int w);
        logic [IN_W-1:0] wd;
        for (int j = 0; j < IN_B; j++) begin
            if (w == 0 && j >= LEAD) wd[IN_W-1-8*j -: 8] = 8'hA5 ^ 8'(j);
            else if (w == 0)         wd[IN_W-1-8*j -: 8] = oct(c, j);
            else                     wd[IN_W-1-8*j -: 8] = oct(c, LEAD + (w - 1) * IN_B + j);
        end
        return wd;
    endfunction

    // Scoreboard driver side: expected output words pushed before the cell is sent.
    task automatic push_cell(input int c);
        for (int k = 0; k < OUT_WORDS; k++) begin
            logic [OUT_W-1:0] ow;
            for (int j = 0; j < OUT_B; j++) ow[OUT_W-1-8*j -: 8] = oct(c, k * OUT_B + j);
            exp_q.push_back({(k == 0), (k == OUT_WORDS - 1), ow});
        end
    endtask

    task automatic send_cell(input int c, input bit nosop, input bit errw,
                             input bit badpar, input bit ok);
        if (ok) push_cell(c);
        for (int w = 0; w < IN_WORDS; w++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = in_word(c, w);
            in_sop   = (w == 0) && !nosop;
            in_err   = errw && (w == IN_WORDS - 1);
            in_par   = (badpar && w == 1) ? ^in_data : ~^in_data;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_partial(input int c, input int n);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = in_word(c, w);
            in_sop   = (w == 0);
            in_err   = 1'b0;
            in_par   = ~^in_data;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic drain_all();
        @(posedge clk);
        drain = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        @(posedge clk);
        drain = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Pulse counters, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_soc  += int'(soc);
            n_serr += int'(soc_err);
            n_ovf  += int'(ovf_err);
            n_par  += int'(par_err);
            n_udf  += int'(udf_err);
        end
    end

    // Scoreboard monitor: pops and compares every word the design presents.
    always @(negedge clk) begin
        if (rst_n && drain && avail) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected output word", longint'(out_data), 0);
                rd_en = 1'b1;
            end else begin
                logic [OUT_W+1:0] e;
                e = exp_q.pop_front();
                chk({out_sop, out_eop, out_data} == e, "R6/R7 output word",
                    longint'({out_sop, out_eop, out_data}), longint'(e));
                rd_en = 1'b1;
            end
        end else begin
            rd_en = poke;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int s0, e0, o0, p0, u0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(avail == 1'b0, "R1 avail after reset", avail, 0);
        chk({soc, soc_err, ovf_err, par_err, udf_err} == 5'b0, "R1 pulses idle",
            {soc, soc_err, ovf_err, par_err, udf_err}, 0);

        // R4 R6 R10: one good cell
        s0 = n_soc;
        send_cell(1, 0, 0, 0, 1);
        chk(avail == 1'b1, "R10 avail after full cell", avail, 1);
        chk(n_soc - s0 == 1, "R4 one soc pulse", n_soc - s0, 1);
        drain_all();
        chk(avail == 1'b0, "R10 avail after read", avail, 0);

        // R10 partial cell not visible; R5 spurious start mark
        e0 = n_serr;
        send_partial(2, IN_WORDS - 1);
        chk(avail == 1'b0, "R10 partial cell hidden", avail, 0);
        send_cell(3, 0, 0, 0, 1);
        chk(n_serr - e0 == 1, "R5 spurious sop flagged", n_serr - e0, 1);
        chk(avail == 1'b1, "R5 new cell stored", avail, 1);
        drain_all();

        // R5 missing start mark
        e0 = n_serr;
        send_cell(4, 1, 0, 0, 0);
        chk(n_serr - e0 == 1, "R5 missing sop flagged", n_serr - e0, 1);
        chk(avail == 1'b0, "R5 missing-sop cell discarded", avail, 0);

        // R9 error flag and parity fault
        send_cell(5, 0, 1, 0, 0);
        chk(avail == 1'b0, "R9 errored cell discarded", avail, 0);
        p0 = n_par;
        send_cell(6, 0, 0, 1, 0);
        chk(n_par - p0 == 1, "R9 parity pulse", n_par - p0, 1);
        chk(avail == 1'b0, "R9 parity cell discarded", avail, 0);

        // R2 fill, R3 overflow
        for (int c = 10; c < 10 + NCELLS; c++) begin
            chk(ready == 1'b1, "R2 ready before full", ready, 1);
            send_cell(c, 0, 0, 0, 1);
        end
        chk(ready == 1'b0, "R2 ready low when full", ready, 0);
        o0 = n_ovf;
        s0 = n_soc;
        send_cell(20, 0, 0, 0, 0);
        chk(n_ovf - o0 == 1, "R3 overflow pulse", n_ovf - o0, 1);
        chk(n_soc - s0 == 1, "R4 soc on dropped cell", n_soc - s0, 1);
        chk(ready == 1'b0, "R3 still full after drop", ready, 0);
        drain_all();
        chk(ready == 1'b1, "R2 ready after drain", ready, 1);

        // R2 R10 writes and reads in the same cycles
        @(posedge clk);
        drain = 1'b1;
        for (int c = 30; c < 36; c++) send_cell(c, 0, 0, 0, 1);
        drain_all();
        chk(avail == 1'b0, "R10 empty after streaming", avail, 0);

        // R8 underflow
        u0 = n_udf;
        @(posedge clk);
        poke = 1'b1;
        @(posedge clk);
        poke = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_udf - u0 == 1, "R8 underflow pulse", n_udf - u0, 1);
        chk(avail == 1'b0, "R8 empty read no effect", avail, 0);
        send_cell(40, 0, 0, 0, 1);
        drain_all();
        chk(exp_q.size() == 0, "R8 alignment kept after underflow", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end

endmodule